// File: doc/BRIEF.md
# Translation-Cache Flush Coordinator

This block keeps track of pending translation-cache invalidations for a group of cores and turns them into flush commands. Each core owns two flags. The first marks a flush that must reach its own cache. The second marks an invalidation that has to reach every other core. Invalidation events set these flags through per-core set inputs. Nothing is flushed at that point.

Work happens only when a core pulses its checkpoint strobe. A checkpoint flushes the core's own cache if its own flag is set. If the strobe also carries the global qualifier and the core's broadcast flag is set, every other core is flushed as well. Those other cores then lose their own pending flushes, because the broadcast has already covered them.

Checkpoint strobes are latched, and the block serves them one at a time, lowest core index first. Each issued flush line stays high until the target core acknowledges it. A busy output covers the whole time any flush line is outstanding.

Top module: `tlb_flush_coord`

## Requirements
- R1: After reset both flags of every core are clear, `flush_o` is all zero and `busy_o` is low.
- R2: A checkpoint from core k that finds its own-flush flag set drives `flush_o[k]` high two clock edges after the strobe is sampled. The flag is then cleared, so a second checkpoint with nothing new issues no flush to k.
- R3: A checkpoint sent without the global qualifier issues no broadcast and leaves the requester's broadcast flag set. A later global checkpoint from the same core still broadcasts.
- R4: A global checkpoint from core k whose broadcast flag is set drives `flush_o` high for every core except k. Bit k is also set only if k's own-flush flag was set.
- R5: Every core that receives a broadcast flush has its own-flush flag cleared.
- R6: A broadcast clears the requester's broadcast flag, so a repeated global checkpoint issues nothing further.
- R7: Only one checkpoint is in service at a time. Checkpoints strobed in the same cycle are served lowest index first. The next one is granted only after all flushes of the previous one are acknowledged, one cycle after `busy_o` falls.
- R8: Each `flush_o[i]` stays high until `flush_ack_i[i]` is sampled high, and drops at that edge. `busy_o` is high exactly while any flush line is high. An acknowledge for a line that is low has no effect.
- R9: If a set input for a flag is high in the same cycle that a service clears that flag, the flag stays set.
- R10: A checkpoint that finds nothing to flush issues no flush and does not raise `busy_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_local_i | input | NUM_CORES | Per-core request to mark an own-cache flush pending |
| set_global_i | input | NUM_CORES | Per-core request to mark a broadcast pending |
| ckpt_i | input | NUM_CORES | Per-core checkpoint strobe |
| ckpt_global_i | input | NUM_CORES | Global qualifier, sampled together with `ckpt_i` |
| flush_ack_i | input | NUM_CORES | Per-core acknowledge of a flush command |
| flush_o | output | NUM_CORES | Per-core flush command, held until acknowledged |
| busy_o | output | 1 | High while any flush command is outstanding |

## Verification
Two functions can hit the same flag in one clock edge. A new invalidation can set a flag at the very edge where a checkpoint service clears it. This can happen to the requester's own flag or to the own-flush flag of a core being reached by a broadcast.

The bench provokes this by driving the set inputs in exactly the cycle before the grant edge. It does this in directed cases and in about a quarter of the random rounds. The result is judged by a later checkpoint: it must still flush the core whose flag was set again.

A second overlap is between simultaneous checkpoint strobes and the one-at-a-time rule. It is judged by the order in which flush lines appear.

// File: rtl/tfc_pkg.sv
package tfc_pkg;
   // Outcome of serving one checkpoint
   typedef struct packed {
      logic own_hit;
      logic bcast_hit;
   } tfc_outcome_t;
endpackage

// File: rtl/tfc_flag_bank.sv
module tfc_flag_bank #(
   parameter int NUM_CORES = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_CORES-1:0] set_i,
   input  logic [NUM_CORES-1:0] clr_i,
   output logic [NUM_CORES-1:0] flag_o
);
   // one flag per core; a set beats a clear in the same cycle
   for (genvar i = 0; i < NUM_CORES; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         flag_o[i] <= 1'b0;
         else if (set_i[i])  flag_o[i] <= 1'b1;
         else if (clr_i[i])  flag_o[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/tfc_prio_pick.sv
module tfc_prio_pick #(
   parameter int NUM_CORES = 4
) (
   input  logic [NUM_CORES-1:0] req_i,
   output logic [NUM_CORES-1:0] grant_o
);
   logic [NUM_CORES:0] blocked;
   assign blocked[0] = 1'b0;
   for (genvar i = 0; i < NUM_CORES; i++) begin : g_chain
      assign grant_o[i]   = req_i[i] & ~blocked[i];
      assign blocked[i+1] = blocked[i] | req_i[i];
   end
endmodule

// File: rtl/tfc_service.sv
module tfc_service
   import tfc_pkg::*;
#(
   parameter int NUM_CORES = 4
) (
   input  logic                 enable_i,
   input  logic [NUM_CORES-1:0] grant_i,
   input  logic [NUM_CORES-1:0] own_pend_i,
   input  logic [NUM_CORES-1:0] bcast_pend_i,
   input  logic [NUM_CORES-1:0] gqual_i,
   output logic [NUM_CORES-1:0] flush_vec_o,
   output logic [NUM_CORES-1:0] clr_own_o,
   output logic [NUM_CORES-1:0] clr_bcast_o
);
   tfc_outcome_t res;

   always_comb begin
      res.own_hit   = enable_i & |(grant_i & own_pend_i);
      res.bcast_hit = enable_i & |(grant_i & gqual_i & bcast_pend_i);
      flush_vec_o   = '0;
      if (res.own_hit)   flush_vec_o = flush_vec_o | grant_i;
      if (res.bcast_hit) flush_vec_o = flush_vec_o | ~grant_i;
      // every flushed core has its own-flush work done
      clr_own_o   = flush_vec_o;
      clr_bcast_o = res.bcast_hit ? grant_i : '0;
   end
endmodule

// File: rtl/tlb_flush_coord.sv
module tlb_flush_coord #(
   parameter int NUM_CORES = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_CORES-1:0] set_local_i,
   input  logic [NUM_CORES-1:0] set_global_i,
   input  logic [NUM_CORES-1:0] ckpt_i,
   input  logic [NUM_CORES-1:0] ckpt_global_i,
   input  logic [NUM_CORES-1:0] flush_ack_i,
   output logic [NUM_CORES-1:0] flush_o,
   output logic                 busy_o
);
   localparam int W = NUM_CORES;

   initial begin
      assert (NUM_CORES >= 2) else $error("NUM_CORES must be at least 2");
   end

   logic [W-1:0] loc_pend, glob_pend;
   logic [W-1:0] ckpt_req, ckpt_gq;
   logic [W-1:0] outstanding;
   logic [W-1:0] grant, served;
   logic [W-1:0] flush_vec, clr_loc, clr_glob;
   logic         idle;

   assign idle   = ~|outstanding;
   assign served = idle ? grant : '0;

   tfc_flag_bank #(.NUM_CORES(W)) u_loc (
      .clk(clk), .rst_n(rst_n), .set_i(set_local_i), .clr_i(clr_loc), .flag_o(loc_pend));

   tfc_flag_bank #(.NUM_CORES(W)) u_glob (
      .clk(clk), .rst_n(rst_n), .set_i(set_global_i), .clr_i(clr_glob), .flag_o(glob_pend));

   tfc_prio_pick #(.NUM_CORES(W)) u_pick (
      .req_i(ckpt_req), .grant_o(grant));

   tfc_service #(.NUM_CORES(W)) u_svc (
      .enable_i(idle), .grant_i(grant), .own_pend_i(loc_pend), .bcast_pend_i(glob_pend),
      .gqual_i(ckpt_gq), .flush_vec_o(flush_vec), .clr_own_o(clr_loc), .clr_bcast_o(clr_glob));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ckpt_req    <= '0;
         ckpt_gq     <= '0;
         outstanding <= '0;
      end else begin
         ckpt_req <= (ckpt_req & ~served) | ckpt_i;
         ckpt_gq  <= (ckpt_gq & ~served) | (ckpt_i & ckpt_global_i);
         if (idle) outstanding <= flush_vec;
         else      outstanding <= outstanding & ~flush_ack_i;
      end
   end

   assign flush_o = outstanding;
   assign busy_o  = ~idle;
endmodule

// File: rtl/tfc_checker.sv
module tfc_checker #(
   parameter int NUM_CORES = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_CORES-1:0] set_local_i,
   input logic [NUM_CORES-1:0] flush_ack_i,
   input logic [NUM_CORES-1:0] flush_o,
   input logic                 busy_o,
   input logic [NUM_CORES-1:0] loc_pend
);
   for (genvar i = 0; i < NUM_CORES; i++) begin : g_bit
      AST_FLUSH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
         (flush_o[i] && !flush_ack_i[i]) |=> flush_o[i]); // R8
      AST_FLUSH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
         (flush_o[i] && flush_ack_i[i]) |=> !flush_o[i]); // R8
      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         set_local_i[i] |=> loc_pend[i]); // R9
   end

   AST_NO_NEW_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> ((flush_o & ~$past(flush_o)) == '0)); // R7

   AST_ISSUE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy_o)) |-> ($countones(flush_o) == 1 ||
                           $countones(flush_o) == NUM_CORES - 1 ||
                           $countones(flush_o) == NUM_CORES)); // R4
endmodule

bind tlb_flush_coord tfc_checker #(.NUM_CORES(NUM_CORES)) u_chk (
   .clk(clk), .rst_n(rst_n), .set_local_i(set_local_i), .flush_ack_i(flush_ack_i),
   .flush_o(flush_o), .busy_o(busy_o), .loc_pend(loc_pend));

// File: tb/tlb_flush_coord_tb.sv
module tlb_flush_coord_tb;
   localparam int N = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [N-1:0] set_loc = '0, set_glob = '0, ckpt = '0, ckpt_g = '0, ack = '0;
   logic [N-1:0] flush;
   logic         busy;
   logic [N-1:0] m_loc = '0, m_glob = '0;
   int checks = 0, fails = 0;

   tlb_flush_coord #(.NUM_CORES(N)) u_dut (
      .clk(clk), .rst_n(rst_n), .set_local_i(set_loc), .set_global_i(set_glob),
      .ckpt_i(ckpt), .ckpt_global_i(ckpt_g), .flush_ack_i(ack),
      .flush_o(flush), .busy_o(busy));

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   function automatic logic [N-1:0] exp_vec(input int k, input bit g);
      logic [N-1:0] me, v;
      me = '0; me[k] = 1'b1;
      v = m_loc[k] ? me : '0;
      if (g && m_glob[k]) v = v | ~me;
      return v;
   endfunction

   task automatic pend(input logic [N-1:0] l, input logic [N-1:0] g);
      @(negedge clk); set_loc = l; set_glob = g;
      @(negedge clk); set_loc = '0; set_glob = '0;
      m_loc |= l; m_glob |= g;
   endtask

   task automatic ckpt_run(input int k, input bit g, input logic [N-1:0] late, input string rq);
      logic [N-1:0] e;
      bit b;
      e = exp_vec(k, g);
      b = g && m_glob[k];
      @(negedge clk); ckpt[k] = 1'b1; ckpt_g[k] = g;
      @(negedge clk); ckpt = '0; ckpt_g = '0; set_loc = late;
      @(negedge clk); set_loc = '0;
      chk(flush == e, rq, flush, e);
      chk(busy == (e != 0), "R10", busy, e != 0);
      m_loc = (m_loc & ~e) | late;
      if (b) m_glob[k] = 1'b0;
      if (e != 0) begin
         @(negedge clk);
         chk(flush == e, "R8", flush, e);
         ack = e;
         @(negedge clk); ack = '0;
         chk(flush == 0 && !busy, "R8", {flush, busy}, 0);
      end
   endtask

   initial begin
      #(8 * 200000);
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      chk(flush == 0 && !busy, "R1", {flush, busy}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(flush == 0 && !busy, "R1", {flush, busy}, 0);
      ckpt_run(0, 1'b1, '0, "R1");
      ckpt_run(3, 1'b0, '0, "R10");

      // own flush then cleared
      pend(4'b0100, '0);
      ckpt_run(2, 1'b0, '0, "R2");
      ckpt_run(2, 1'b0, '0, "R2");

      // non-global keeps broadcast flag; global consumes it
      pend('0, 4'b0001);
      ckpt_run(0, 1'b0, '0, "R3");
      ckpt_run(0, 1'b1, '0, "R4");
      ckpt_run(0, 1'b1, '0, "R6");

      // broadcast clears other locals
      pend(4'b0011, 4'b0100);
      ckpt_run(2, 1'b1, '0, "R4");
      ckpt_run(0, 1'b0, '0, "R5");
      ckpt_run(1, 1'b0, '0, "R5");

      // set at clear edge wins: own and broadcast receiver
      pend(4'b0001, '0);
      ckpt_run(0, 1'b0, 4'b0001, "R9");
      ckpt_run(0, 1'b0, '0, "R9");
      pend(4'b0010, 4'b1000);
      ckpt_run(3, 1'b1, 4'b0010, "R9");
      ckpt_run(1, 1'b0, '0, "R9");

      // priority among simultaneous strobes
      pend(4'b0110, '0);
      @(negedge clk); ckpt = 4'b0110;
      @(negedge clk); ckpt = '0;
      @(negedge clk);
      chk(flush == 4'b0010, "R7", flush, 4'b0010);
      ack = 4'b0010;
      @(negedge clk); ack = '0;
      chk(flush == 0 && !busy, "R7", {flush, busy}, 0);
      @(negedge clk);
      chk(flush == 4'b0100, "R7", flush, 4'b0100);
      ack = 4'b0100;
      @(negedge clk); ack = '0;
      m_loc = '0;

      // partial acknowledge and stray acknowledge
      pend('0, 4'b0010);
      @(negedge clk); ckpt[1] = 1'b1; ckpt_g[1] = 1'b1;
      @(negedge clk); ckpt = '0; ckpt_g = '0;
      @(negedge clk);
      chk(flush == 4'b1101, "R4", flush, 4'b1101);
      ack = 4'b0011;
      @(negedge clk); ack = '0;
      chk(flush == 4'b1100 && busy, "R8", {flush, busy}, {4'b1100, 1'b1});
      ack = 4'b1100;
      @(negedge clk); ack = '0;
      chk(flush == 0 && !busy, "R8", {flush, busy}, 0);
      m_glob[1] = 1'b0;

      // constrained random rounds
      for (int it = 0; it < 80; it++) begin
         logic [N-1:0] l, g, late;
         int k;
         bit q;
         l = N'($urandom);
         g = N'($urandom) & N'($urandom);
         pend(l, g);
         k = int'($urandom % N);
         q = 1'(($urandom % 3) != 0);
         late = (($urandom % 4) == 0) ? N'($urandom) : '0;
         ckpt_run(k, q, late, (q && m_glob[k]) ? "R4" : "R2");
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule